// File: doc/BRIEF.md
# Rewindable FIFO Buffer with Occupancy Flags

This block is a single-clock first-in/first-out buffer for 9-bit words: eight data bits plus one spare bit that a parity or control marker can use. A producer pushes a word with a write strobe and a consumer pops one with a read strobe. Two circular pointers select the storage location, so the ports carry no address. Three active-low flags show whether the buffer is empty, full, or more than half full. The flags stop writes past full and reads past empty. The depth is a power-of-two parameter, 1024 words by default.

A rewind input moves the read pointer back to location zero and leaves the write pointer alone, so everything written since reset can be sent again. This is typical on a link that repeats a short frame after an error. The half-full flag follows an asymmetric rule: it is set by the write that takes the fill level above half the depth, and it is cleared by the read that brings the fill level back to half or below.

Popped data is registered. It appears for one cycle together with a valid pulse, and between pops the data bus rests at zero, standing in for a released bus. The flags are registered too: each one shows the effect of a strobe in the cycle right after the clock edge that sampled it.

Top module: `fifo_rt`

## Requirements
- R1: While reset is low, and right after it is released, `empty_no` is 0, `full_no` is 1, `half_no` is 1, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: Words come out in the order they were written, with all 9 bits intact, on any mix of strobes.
- R3: A write strobe while `full_no` is 0 is ignored. The write pointer and the fill level do not move, and no stored word is overwritten.
- R4: A read strobe while `empty_no` is 0 is ignored. `rvalid_o` stays 0 in the following cycle and `rdata_o` stays 0.
- R5: `empty_no` is 0 exactly when the fill level is zero. Every flag shows the new fill level one cycle after the clock edge that sampled the strobe.
- R6: Starting from reset, `full_no` goes to 0 after exactly DEPTH accepted writes with no read in between.
- R7: `half_no` is 0 exactly when the fill level is greater than DEPTH/2. It is set by the write that crosses this level and released by the read that returns to it.
- R8: A rewind (`rt_i` high with both strobes low) sets the read pointer to location zero and keeps the write pointer. The fill level then equals the write pointer's location index, and the flags follow it. The next pop returns the first word written after reset.
- R9: A rewind request in a cycle where either strobe is high is ignored. The strobes act as if `rt_i` were low.
- R10: A read and a write in the same cycle, while the buffer is neither empty nor full, both take effect and leave the fill level and all three flags unchanged.
- R11: `rvalid_o` is high only in the cycle after an accepted read. In every other cycle `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one word per high cycle |
| wdata_i | input | DATA_W | Word to store |
| rd_i | input | 1 | Read strobe, one word per high cycle |
| rt_i | input | 1 | Rewind read pointer to location zero |
| rdata_o | output | DATA_W | Popped word, zero when not valid |
| rvalid_o | output | 1 | High for one cycle per accepted read |
| empty_no | output | 1 | Low when no word is stored |
| full_no | output | 1 | Low when DEPTH words are stored |
| half_no | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The assertions check every cycle that:
- a write into a full buffer leaves the pointer and fill level still;
- a read from an empty buffer yields no valid pulse;
- the flags never contradict each other;
- a combined read and write keeps the flags steady;
- a rewind lands the read pointer at zero, or is dropped under an active strobe;
- the idle data bus stays at zero.

Only the bench scenarios can show the rest: the order and content of the data, the exact write that raises full or half-full, and the fill level recomputed after a rewind at every starting level. The bench covers these by sweeping every strobe combination from every fill level of a small buffer, then draining and comparing each word.

// File: rtl/fifo_rt_pkg.sv
`timescale 1ns/1ps
package fifo_rt_pkg;
  localparam int unsigned DEF_DATA_W = 9;
  localparam int unsigned DEF_DEPTH  = 1024;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } op_e;
endpackage

// File: rtl/fifo_rt_ptrs.sv
`timescale 1ns/1ps
module fifo_rt_ptrs
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              rt_i,
  input  logic              full_ni,
  input  logic              empty_ni,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] wptr_o,
  output logic [ADDR_W-1:0] rptr_o,
  output logic [CNT_W-1:0]  occ_d_o
);
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0]  occ_q, occ_d;
  logic              rt_ok;
  op_e               op;

  assign wr_en_o = wr_i & full_ni;
  assign rd_en_o = rd_i & empty_ni;
  assign rt_ok   = rt_i & ~wr_i & ~rd_i;
  assign op      = op_e'({wr_en_o, rd_en_o});

  always_comb begin
    occ_d = occ_q;
    if (rt_ok) begin
      occ_d = {1'b0, wptr_q};
    end else begin
      unique case (op)
        OP_PUSH: occ_d = occ_q + 1'b1;
        OP_POP:  occ_d = occ_q - 1'b1;
        default: occ_d = occ_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      occ_q <= occ_d;
      if (wr_en_o) wptr_q <= wptr_q + 1'b1;
      if (rt_ok)        rptr_q <= '0;
      else if (rd_en_o) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign occ_d_o = occ_d;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_ni && wr_i && !rd_i) |=> ($stable(wptr_q) && $stable(occ_q)));

  p_rt_rewind_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_i && !wr_i && !rd_i) |=> (rptr_q == '0 && $stable(wptr_q)));

  p_rt_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_i && rd_i && empty_ni) |=> (rptr_q == ADDR_W'($past(rptr_q) + 1'b1)));
endmodule

// File: rtl/fifo_rt_flags.sv
`timescale 1ns/1ps
module fifo_rt_flags
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1,
  localparam int unsigned HALF   = DEPTH / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] occ_d_i,
  output logic             empty_no,
  output logic             full_no,
  output logic             half_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_no <= 1'b0;
      full_no  <= 1'b1;
      half_no  <= 1'b1;
    end else begin
      empty_no <= (occ_d_i != '0);
      full_no  <= (occ_d_i != CNT_W'(DEPTH));
      half_no  <= !(occ_d_i > CNT_W'(HALF));
    end
  end

  p_flag_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!empty_no && !full_no));

  p_half_under_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !half_no);
endmodule

// File: rtl/fifo_rt_mem.sv
`timescale 1ns/1ps
module fifo_rt_mem
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rptr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) store_q[wptr_i] <= wdata_i;
  end

  // idle bus rests at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      rdata_o  <= rd_en_i ? store_q[rptr_i] : '0;
    end
  end

  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
endmodule

// File: rtl/fifo_rt.sv
`timescale 1ns/1ps
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              rt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              empty_no,
  output logic              full_no,
  output logic              half_no
);
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0]  occ_d;

  fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .rt_i     (rt_i),
    .full_ni  (full_no),
    .empty_ni (empty_no),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .wptr_o   (wptr),
    .rptr_o   (rptr),
    .occ_d_o  (occ_d)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .occ_d_i  (occ_d),
    .empty_no (empty_no),
    .full_no  (full_no),
    .half_no  (half_no)
  );

  fifo_rt_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wptr_i   (wptr),
    .wdata_i  (wdata_i),
    .rd_en_i  (rd_en),
    .rptr_i   (rptr),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_no) |=> !rvalid_o);

  p_both_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && empty_no && full_no) |=> $stable({empty_no, full_no, half_no}));
endmodule

// File: tb/fifo_rt_tb.sv
`timescale 1ns/1ps
module fifo_rt_tb;
  localparam int D  = 8;
  localparam int DW = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0, rd_i = 1'b0, rt_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o, empty_no, full_no, half_no;

  always #2 clk_i = ~clk_i;

  fifo_rt #(.DATA_W(DW), .DEPTH(D)) u_dut (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .rd_i, .rt_i,
    .rdata_o, .rvalid_o, .empty_no, .full_no, .half_no
  );

  int checks = 0;
  int fails  = 0;
  int m_occ, m_wp, m_rp;
  logic [DW-1:0] m_mem [D];
  logic [DW-1:0] lfsr = 9'h1a5;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nd();
    lfsr = {lfsr[7:0], lfsr[8] ^ lfsr[4]};
    return lfsr;
  endfunction

  function automatic string tag_of(bit w, bit r, bit t);
    if (t && !w && !r) return "R8";
    if (t) return "R9";
    if (w && r && m_occ != 0 && m_occ != D) return "R10";
    if (w && m_occ == D) return "R3";
    if (r && m_occ == 0) return "R4";
    return "R5";
  endfunction

  task automatic check_flags(string tag);
    chk(tag, "empty_no", int'(empty_no), int'(m_occ != 0));
    chk(tag, "full_no",  int'(full_no),  int'(m_occ != D));
    chk(tag, "half_no",  int'(half_no),  int'(!(m_occ > D/2)));
  endtask

  task automatic step(bit w, logic [DW-1:0] d, bit r, bit t, string tag);
    bit wok, rok, rtok;
    int ev, ed;
    @(negedge clk_i);
    wr_i = w; wdata_i = d; rd_i = r; rt_i = t;
    wok  = w && (m_occ != D);
    rok  = r && (m_occ != 0);
    rtok = t && !w && !r;
    ev   = int'(rok);
    ed   = rok ? int'(m_mem[m_rp]) : 0;
    if (wok) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % D; end
    if (rok) m_rp = (m_rp + 1) % D;
    m_occ = m_occ + int'(wok) - int'(rok);
    if (rtok) begin m_rp = 0; m_occ = m_wp; end
    @(posedge clk_i); #1;
    chk(tag, "rvalid_o", int'(rvalid_o), ev);
    chk(tag, "rdata_o",  int'(rdata_o),  ed);
    check_flags(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_i = 0; rd_i = 0; rt_i = 0;
    m_occ = 0; m_wp = 0; m_rp = 0;
    @(negedge clk_i);
    // R1: values held during reset
    chk("R1", "empty_no", int'(empty_no), 0);
    chk("R1", "full_no",  int'(full_no),  1);
    chk("R1", "half_no",  int'(half_no),  1);
    chk("R1", "rvalid_o", int'(rvalid_o), 0);
    chk("R1", "rdata_o",  int'(rdata_o),  0);
    rst_ni = 1'b1;
  endtask

  task automatic drain(string tag);
    while (m_occ > 0) step(0, '0, 1, 0, tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    step(0, '0, 0, 0, "R1");

    // R6 / R7: fill one word at a time, flags checked each step
    for (int i = 0; i < D; i++) step(1, nd(), 0, 0, (i == D/2) ? "R7" : "R6");
    step(1, nd(), 0, 0, "R3");
    step(1, nd(), 0, 0, "R3");
    // R7: half flag released on crossing back
    for (int i = 0; i < D/2 + 1; i++) step(0, '0, 1, 0, "R7");
    drain("R2");
    step(0, '0, 1, 0, "R4");
    step(0, '0, 0, 0, "R11");

    // R8: rewind after partial read
    do_reset();
    for (int i = 0; i < 5; i++) step(1, nd(), 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, "R2");
    step(0, '0, 0, 1, "R8");
    drain("R8");

    // sweep every strobe combination from every fill level
    for (int lvl = 0; lvl <= D; lvl++) begin
      for (int c = 0; c < 8; c++) begin
        do_reset();
        for (int i = 0; i < lvl; i++) step(1, nd(), 0, 0, "R6");
        step(c[0], nd(), c[1], c[2], tag_of(c[0], c[1], c[2]));
        step(0, '0, 0, 0, "R11");
        drain("R2");
      end
    end

    // R2: random soak with rewinds
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] s;
      s = nd();
      step(s[0] | s[3], nd(), s[1] & ~s[5], s[2] & s[6] & s[7], "R2");
    end
    drain("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule